// File: doc/BRIEF.md
# Mixed Page-Size Table Walker

This block walks a three-level, 8-byte-entry page table to refill a TLB that can hold both 4KB and 2MB mappings. A translation request carries a 43-bit virtual address. Starting at a root table address, the walker issues one memory read per level. The reads go through a simple request/response port that never has more than one read in flight.

A level-2 entry with its large-page flag set ends the walk after two reads, and the walker returns a 2MB mapping. In every other case the walker reads the level-3 entry and returns a 4KB mapping. The result leaves as a single-cycle refill record holding the virtual page number, the physical page number and a size bit. For a 2MB record both page numbers have their low nine bits cleared, so the TLB can compare only VA bits 42:21 for that entry.

Top module: `mixed_walk`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `mem_req_valid`=0 and `refill_valid`=0.
- R2: The first read goes to `root_ptr` + 8 × VA[42:32].
- R3: Each later read goes to {previous entry[51:12], 12'b0} + 8 × index. The index is VA[31:21] at level 2 and VA[20:12] at level 3. Entry bits 63:52 and 11:0 do not affect the address.
- R4: If the level-2 entry has bit 7 set, the walk makes exactly two reads. The refill then has `refill_huge`=1, `refill_vpn`={VA[42:21], 9'b0} and `refill_ppn`={entry[51:21], 9'b0}.
- R5: Otherwise the walk makes exactly three reads. The refill then has `refill_huge`=0, `refill_vpn`=VA[42:12] and `refill_ppn`=level-3 entry[51:12].
- R6: Bit 7 of a level-1 or level-3 entry has no effect on the walk length or on the result.
- R7: At most one read is outstanding. After a read is accepted, `mem_req_valid` stays low until its response arrives.
- R8: `refill_valid` is high for exactly one cycle, and `req_ready` is 1 in the following cycle.
- R9: `req_valid` and `req_va` are ignored while a walk is in progress.
- R10: While `mem_req_ready` is low, a pending read holds `mem_req_valid` high with `mem_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 52 | Physical address of the level-1 table |
| req_valid | input | 1 | Start a walk |
| req_va | input | 43 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| refill_valid | output | 1 | Refill record valid (one cycle) |
| refill_vpn | output | 31 | VA[42:12], low 9 bits zero for 2MB |
| refill_ppn | output | 40 | Physical page number, low 9 bits zero for 2MB |
| refill_huge | output | 1 | 1 = 2MB mapping, 0 = 4KB |

## Verification
The walker is driven by four kinds of table content:
- A plain 4KB chain, which separates the three-read path from the two-read path.
- A level-2 leaf, which shows whether the early exit and the low-bit masking occur.
- Chains with bit 7 set at level 1 or level 3, which reveal a flag decoded at the wrong level.
- Chains with all-ones indices and junk outside bits 51:12, which expose index-scaling and field-slicing errors.

Memory back-pressure and requests arriving during a walk check that reads are held steady and that a busy walker ignores new work.

// File: rtl/mixed_walk.sv
module mixed_walk #(
  parameter int PA_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  root_ptr,
  input  logic             req_valid,
  input  logic [42:0]      req_va,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             refill_valid,
  output logic [30:0]      refill_vpn,
  output logic [PA_W-13:0] refill_ppn,
  output logic             refill_huge
);
  localparam int PPN_W = PA_W - 12;
  localparam int HUGE_W = 9;
  localparam int LEAF_BIT = 7;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, DONE} st_t;

  st_t             st;
  logic [1:0]      lvl;
  logic [42:0]     va_q;
  logic [PA_W-1:0] base_q;
  logic            huge_q;
  logic [10:0]     idx;

  always_comb begin
    case (lvl)
      2'd1:    idx = va_q[42:32];
      2'd2:    idx = va_q[31:21];
      default: idx = {2'b00, va_q[20:12]};
    endcase
  end

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == ISSUE);
  assign mem_req_addr  = base_q + PA_W'({idx, 3'b000});
  assign refill_valid  = (st == DONE);
  assign refill_huge   = huge_q;
  assign refill_vpn    = huge_q ? {va_q[42:21], {HUGE_W{1'b0}}} : va_q[42:12];
  assign refill_ppn    = huge_q ? {base_q[PA_W-1:21], {HUGE_W{1'b0}}} : base_q[PA_W-1:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      lvl    <= 2'd1;
      va_q   <= '0;
      base_q <= '0;
      huge_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= root_ptr;
          lvl    <= 2'd1;
          huge_q <= 1'b0;
          st     <= ISSUE;
        end
        ISSUE: if (mem_req_ready) st <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          base_q <= {mem_rsp_data[PA_W-1:12], 12'b0};
          if (lvl == 2'd2 && mem_rsp_data[LEAF_BIT]) begin
            huge_q <= 1'b1;
            st     <= DONE;
          end else if (lvl == 2'd3) begin
            st <= DONE;
          end else begin
            lvl <= lvl + 2'd1;
            st  <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [PPN_W-1:0] unused_ppn;
  assign unused_ppn = refill_ppn;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !refill_valid));

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_refill_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> (!refill_valid && req_ready));

  p_huge_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && refill_huge) |-> (refill_vpn[8:0] == 9'd0 && refill_ppn[8:0] == 9'd0));

  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/mixed_walk_test.sv
module mixed_walk_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [51:0] root_ptr = 52'h10000;
  logic        req_valid = 0;
  logic [42:0] req_va = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_req_ready = 1;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic        refill_valid;
  logic [30:0] refill_vpn;
  logic [39:0] refill_ppn;
  logic        refill_huge;

  always #10 clk = ~clk;

  mixed_walk uut (.*);

  int total = 0, bad = 0;
  logic [51:0] m_a[8];
  logic [63:0] m_d[8];
  logic [51:0] alog[8];
  int refs = 0;
  int stall = 0;
  int stall_left = 0;
  logic pending = 0;
  logic [51:0] pend_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mclear();
    for (int i = 0; i < 8; i++) begin m_a[i] = '1; m_d[i] = '0; end
  endtask

  function automatic logic [63:0] mlook(input logic [51:0] a);
    for (int i = 0; i < 8; i++) if (m_a[i] == a) return m_d[i];
    return 64'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (pending) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mlook(pend_addr);
        pending = 0;
      end else begin
        mem_rsp_valid = 0;
      end
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          mem_req_ready = 0;
          stall_left--;
        end else begin
          mem_req_ready = 1;
          pending = 1;
          pend_addr = mem_req_addr;
          if (refs < 8) alog[refs] = mem_req_addr;
          refs++;
          stall_left = stall;
        end
      end else begin
        mem_req_ready = 1;
      end
    end
  end

  task automatic walk(input logic [42:0] va, input bit busy_poke,
                      output logic [30:0] vpn, output logic [39:0] ppn, output logic hg);
    int n;
    refs = 0;
    stall_left = stall;
    @(negedge clk);
    req_va = va; req_valid = 1;
    @(negedge clk);
    if (busy_poke) req_va = ~va; else req_valid = 0;
    n = 0;
    while (!refill_valid && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk(0, "watchdog", 0, 1);
    vpn = refill_vpn; ppn = refill_ppn; hg = refill_huge;
    req_valid = 0;
    @(negedge clk);
    chk(!refill_valid && req_ready, "R8 pulse/ready", {refill_valid, req_ready}, 2'b01);
  endtask

  function automatic logic [51:0] nb(input logic [63:0] e);
    return {e[51:12], 12'b0};
  endfunction

  task automatic t_4k(input logic [10:0] i1, input logic [10:0] i2, input logic [8:0] i3,
                      input logic [63:0] e1, input logic [63:0] e2, input logic [63:0] e3,
                      input bit poke, input string tg);
    logic [42:0] va; logic [30:0] vpn; logic [39:0] ppn; logic hg;
    logic [51:0] a1, a2, a3;
    va = {i1, i2, i3, 12'hABC};
    a1 = root_ptr + {i1, 3'b000};
    a2 = nb(e1) + {i2, 3'b000};
    a3 = nb(e2) + {i3, 3'b000};
    mclear();
    m_a[0] = a1; m_d[0] = e1; m_a[1] = a2; m_d[1] = e2; m_a[2] = a3; m_d[2] = e3;
    walk(va, poke, vpn, ppn, hg);
    chk(refs == 3, {tg, " R5 three reads"}, refs, 3);
    chk(alog[0] == a1, {tg, " R2 L1 addr"}, alog[0], a1);
    chk(alog[1] == a2 && alog[2] == a3, {tg, " R3 L2/L3 addr"}, {alog[1][31:0], alog[2][31:0]}, {a2[31:0], a3[31:0]});
    chk(hg == 0 && vpn == va[42:12], {tg, " R5 vpn/size"}, {hg, vpn}, {1'b0, va[42:12]});
    chk(ppn == e3[51:12], {tg, " R5 ppn"}, ppn, e3[51:12]);
  endtask

  task automatic t_2m(input logic [10:0] i1, input logic [10:0] i2,
                      input logic [63:0] e1, input logic [63:0] e2, input string tg);
    logic [42:0] va; logic [30:0] vpn; logic [39:0] ppn; logic hg;
    logic [51:0] a1, a2;
    va = {i1, i2, 21'h1F_5A5A};
    a1 = root_ptr + {i1, 3'b000};
    a2 = nb(e1) + {i2, 3'b000};
    mclear();
    m_a[0] = a1; m_d[0] = e1; m_a[1] = a2; m_d[1] = e2;
    walk(va, 0, vpn, ppn, hg);
    chk(refs == 2, {tg, " R4 two reads"}, refs, 2);
    chk(alog[1] == a2, {tg, " R3 L2 addr"}, alog[1], a2);
    chk(hg == 1, {tg, " R4 size bit"}, hg, 1);
    chk(vpn == {va[42:21], 9'b0}, {tg, " R4 vpn"}, vpn, {va[42:21], 9'b0});
    chk(ppn == {e2[51:21], 9'b0}, {tg, " R4 ppn"}, ppn, {e2[51:21], 9'b0});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !refill_valid, "R1 reset state",
        {req_ready, mem_req_valid, refill_valid}, 3'b100);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog global", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mclear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_4k(11'h005, 11'h00A, 9'h003, 64'h0000_0000_0002_0000, 64'h0000_0000_0003_0001,
         64'h0000_0012_3456_7000, 0, "plain");
    t_4k(11'h7FF, 11'h7FF, 9'h1FF, 64'hFFF0_0000_4000_0FFF, 64'hABC0_0000_5000_0F7F,
         64'hFFF0_0012_3456_7080, 0, "R6 ones/flags");
    t_2m(11'h012, 11'h345, 64'h0000_0000_0002_0000, 64'h0000_0ABC_DEF1_2080, "huge");
    t_2m(11'h7FF, 11'h000, 64'hFFF0_0000_6000_0080, 64'hFFFF_FFFF_FFFF_FFFF, "huge ones");
    t_4k(11'h100, 11'h200, 9'h0AA, 64'h0000_0000_0007_0000, 64'h0000_0000_0008_0000,
         64'h0000_0000_9999_9000, 1, "R9 busy req");
    stall = 2;
    t_4k(11'h033, 11'h044, 9'h055, 64'h0000_0000_000A_0000, 64'h0000_0000_000B_0000,
         64'h0000_0000_0C0C_0000, 0, "R10 stall");
    t_2m(11'h001, 11'h002, 64'h0000_0000_000D_0000, 64'h0000_0000_00E0_0080, "R10 stall huge");
    stall = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule